// File: doc/BRIEF.md
# Descriptor Fetch Arbiter with Group Locking

This block decides which of several DMA pipes may fetch its next descriptor. Every pipe keeps a count of descriptors that software has announced through single-cycle event pulses. While no lock is held, pipes with a non-zero count take turns in round-robin order. The arbiter raises one fetch request at a time and keeps it until the fetch engine grants it. It then waits for the 16-bit flag field of the fetched descriptor to come back.

The returned flags can carry an in-band lock or release command. A command descriptor with the lock flag makes the issuing pipe the lock owner. From then on, only pipes whose programmed group number matches the owner's group may fetch. Events for masked pipes still count up, and those pipes resume once the owner fetches a command descriptor with the release flag. Two outputs report whether a lock is held and which pipe holds it.

Top module: `pipe_fetch_lock_arb`

## Requirements
- R1: After reset, lock_active is 0, lock_owner is 0, fetch_req is 0 and every pending count is zero.
- R2: With no lock held, pipes with pending descriptors are requested in round-robin order, starting after the pipe served last (pipe 0 first after reset). Only one fetch is outstanding: no new request is raised until the flags of the previous one have returned.
- R3: Flag bit numbering is that of the 16-bit value whose first descriptor byte is bits 7:0. Bit 11 marks a command descriptor, bit 10 requests a lock and bit 9 requests a release. On a descriptor without bit 11, bits 10 and 9 have no effect on the lock.
- R4: A command descriptor with the lock bit, fetched while no lock is held, sets lock_active and makes lock_owner the fetching pipe. Both are visible from the cycle after flag_valid.
- R5: While a lock is held, a pipe whose group number differs from the owner's is never requested, whatever its pending count.
- R6: A release command fetched by any pipe other than the owner leaves the lock and the owner unchanged.
- R7: A release command fetched by the owner clears the lock. Events counted on masked pipes during the lock are kept, and those pipes are served afterwards.
- R8: A lock command from the pipe that already owns the lock changes nothing. A command descriptor with both the lock and release bits, fetched while no lock is held, leaves no lock behind.
- R9: A pending count stops at its maximum (2^CNT_W-1) and does not wrap; exactly that many fetches follow.
- R10: Once raised, fetch_req stays high and fetch_pipe stays unchanged until fetch_gnt is sampled high.
- R11: lock_owner reads 0 whenever lock_active is 0, and the lock owner does not change while no flags return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_add | input | N_PIPES | Per-pipe pulse: one more descriptor announced |
| group_id | input | N_PIPES*GRP_W | Group number of each pipe, pipe p at bits p*GRP_W upward |
| fetch_req | output | 1 | Fetch request for fetch_pipe |
| fetch_pipe | output | IDX_W | Pipe whose descriptor is to be fetched |
| fetch_gnt | input | 1 | Fetch engine accepts the request |
| flag_valid | input | 1 | Flag field of the granted fetch is present |
| flag_data | input | 16 | Flag field of the fetched descriptor |
| lock_active | output | 1 | A pipe holds the lock |
| lock_owner | output | IDX_W | Pipe that holds the lock, 0 when none |

## Verification
The bench places pending work on masked pipes while a lock is held. It confirms that no request appears for them, since a design that masked by pipe index rather than by group would either starve same-group pipes or leak requests to others. It sends release commands from a same-group pipe that does not own the lock, which a design lacking the owner comparison would wrongly honour. It also sends lock and release flags without the command bit, and a descriptor carrying both flags, which would leave a stale lock in a design that resolved the two in the wrong order. Finally it drives more events than a counter can hold and counts the fetches that follow, exposing any wrap-around.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
    localparam int FLAG_W     = 16;
    localparam int FLG_EOB    = 13;
    localparam int FLG_NWD    = 12;
    localparam int FLG_CMD    = 11;
    localparam int FLG_LOCK   = 10;
    localparam int FLG_UNLOCK = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } arb_st_e;
endpackage

// File: rtl/pipe_pending_ctr.sv
module pipe_pending_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic             nonzero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     elig,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            if (!found && elig[(int'(last) + k) % N]) begin
                found = 1'b1;
                pick  = IDX_W'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/pipe_fetch_lock_arb.sv
module pipe_fetch_lock_arb #(
    parameter int N_PIPES = 4,
    parameter int GRP_W   = 2,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(N_PIPES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PIPES-1:0]       evt_add,
    input  logic [N_PIPES*GRP_W-1:0] group_id,
    output logic                     fetch_req,
    output logic [IDX_W-1:0]         fetch_pipe,
    input  logic                     fetch_gnt,
    input  logic                     flag_valid,
    input  logic [15:0]              flag_data,
    output logic                     lock_active,
    output logic [IDX_W-1:0]         lock_owner
);
    import dfa_pkg::*;

    typedef struct packed {
        arb_st_e          st;
        logic [IDX_W-1:0] sel;
        logic [IDX_W-1:0] last;
        logic             lock;
        logic [IDX_W-1:0] owner;
    } arb_state_t;

    arb_state_t       s_d, s_q;
    logic [N_PIPES-1:0] nz, allowed, elig, dec_vec;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [GRP_W-1:0] owner_grp;

    assign owner_grp = group_id[int'(s_q.owner)*GRP_W +: GRP_W];

    genvar gp;
    generate
        for (gp = 0; gp < N_PIPES; gp++) begin : g_pipe
            pipe_pending_ctr #(.CNT_W(CNT_W)) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (evt_add[gp]),
                .dec     (dec_vec[gp]),
                .nonzero (nz[gp])
            );
            assign allowed[gp] = !s_q.lock ||
                                 (group_id[gp*GRP_W +: GRP_W] == owner_grp);
            assign elig[gp]    = nz[gp] && allowed[gp];
        end
    endgenerate

    rr_pick #(.N(N_PIPES), .IDX_W(IDX_W)) u_pick (
        .elig  (elig),
        .last  (s_q.last),
        .found (pick_found),
        .pick  (pick_idx)
    );

    always_comb begin
        s_d     = s_q;
        dec_vec = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (pick_found) begin
                    s_d.sel = pick_idx;
                    s_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (fetch_gnt) begin
                    dec_vec[s_q.sel] = 1'b1;
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (flag_valid) begin
                    s_d.last = s_q.sel;
                    s_d.st   = ST_IDLE;
                    if (flag_data[FLG_CMD]) begin
                        // lock first, release second: a descriptor with both ends unlocked
                        if (flag_data[FLG_LOCK] && !s_d.lock) begin
                            s_d.lock  = 1'b1;
                            s_d.owner = s_q.sel;
                        end
                        if (flag_data[FLG_UNLOCK] && s_d.lock && (s_d.owner == s_q.sel)) begin
                            s_d.lock  = 1'b0;
                            s_d.owner = '0;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.sel   <= '0;
            s_q.last  <= IDX_W'(N_PIPES - 1);
            s_q.lock  <= 1'b0;
            s_q.owner <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_req   = (s_q.st == ST_REQ);
    assign fetch_pipe  = s_q.sel;
    assign lock_active = s_q.lock;
    assign lock_owner  = s_q.owner;
endmodule

// File: rtl/pipe_fetch_lock_arb_chk.sv
module pipe_fetch_lock_arb_chk #(
    parameter int N_PIPES = 4,
    parameter int GRP_W   = 2,
    parameter int IDX_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_PIPES*GRP_W-1:0] group_id,
    input logic                     fetch_req,
    input logic [IDX_W-1:0]         fetch_pipe,
    input logic                     fetch_gnt,
    input logic                     flag_valid,
    input logic [15:0]              flag_data,
    input logic                     lock_active,
    input logic [IDX_W-1:0]         lock_owner
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_gnt) |=> (fetch_req && $stable(fetch_pipe)));

    assert_masked_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && lock_active) |->
        (group_id[int'(fetch_pipe)*GRP_W +: GRP_W] == group_id[int'(lock_owner)*GRP_W +: GRP_W]));

    assert_noncmd_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_valid && !flag_data[11]) |=> $stable(lock_active));

    assert_owner_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !flag_valid) |=> (lock_active && $stable(lock_owner)));

    assert_owner_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_active |-> (lock_owner == '0));

    assert_single_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_gnt) |=> !fetch_req);
endmodule

bind pipe_fetch_lock_arb pipe_fetch_lock_arb_chk #(
    .N_PIPES(N_PIPES), .GRP_W(GRP_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .group_id   (group_id),
    .fetch_req  (fetch_req),
    .fetch_pipe (fetch_pipe),
    .fetch_gnt  (fetch_gnt),
    .flag_valid (flag_valid),
    .flag_data  (flag_data),
    .lock_active(lock_active),
    .lock_owner (lock_owner)
);

// File: tb/pipe_fetch_lock_arb_test.sv
module pipe_fetch_lock_arb_test;
    localparam int N  = 4;
    localparam int GW = 2;
    localparam int CW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_add = '0;
    logic [N*GW-1:0] group_id = {2'd2, 2'd1, 2'd1, 2'd0};
    logic          fetch_req;
    logic [IW-1:0] fetch_pipe;
    logic          fetch_gnt = 1'b0;
    logic          flag_valid = 1'b0;
    logic [15:0]   flag_data = '0;
    logic          lock_active;
    logic [IW-1:0] lock_owner;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pipe_fetch_lock_arb #(.N_PIPES(N), .GRP_W(GW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_add(evt_add), .group_id(group_id),
        .fetch_req(fetch_req), .fetch_pipe(fetch_pipe), .fetch_gnt(fetch_gnt),
        .flag_valid(flag_valid), .flag_data(flag_data),
        .lock_active(lock_active), .lock_owner(lock_owner)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_evt(input logic [N-1:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            evt_add = mask;
            @(negedge clk);
            evt_add = '0;
        end
    endtask

    task automatic do_fetch(input int exp_pipe, input logic [15:0] flags, input string req);
        int w = 0;
        while (!fetch_req && w < 50) begin
            @(negedge clk);
            w++;
        end
        check(fetch_req == 1'b1, req, int'(fetch_req), 1);
        check(int'(fetch_pipe) == exp_pipe, req, int'(fetch_pipe), exp_pipe);
        @(negedge clk);
        check(fetch_req && int'(fetch_pipe) == exp_pipe, "R10", int'(fetch_pipe), exp_pipe);
        fetch_gnt = 1'b1;
        @(negedge clk);
        fetch_gnt = 1'b0;
        check(!fetch_req, "R2", int'(fetch_req), 0);
        flag_valid = 1'b1;
        flag_data  = flags;
        @(negedge clk);
        flag_valid = 1'b0;
        flag_data  = '0;
    endtask

    task automatic expect_lock(input bit act_exp, input int own_exp, input string req);
        check(lock_active == act_exp, req, int'(lock_active), int'(act_exp));
        check(int'(lock_owner) == own_exp, req, int'(lock_owner), own_exp);
    endtask

    task automatic expect_idle(input int cycles, input string req);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (fetch_req) seen = 1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic t_reset;
        check(!lock_active && lock_owner == '0, "R1", int'(lock_active), 0);
        expect_idle(5, "R1");
    endtask

    task automatic t_round_robin;
        add_evt(4'b0111, 1);
        do_fetch(0, 16'h0000, "R2");
        do_fetch(1, 16'h0000, "R2");
        do_fetch(2, 16'h0000, "R2");
        expect_idle(5, "R2");
    endtask

    task automatic t_no_cmd;
        add_evt(4'b1000, 1);
        do_fetch(3, 16'h0600, "R3");
        expect_lock(0, 0, "R3");
    endtask

    task automatic t_lock_mask;
        add_evt(4'b0010, 1);
        do_fetch(1, 16'h0C00, "R4");
        expect_lock(1, 1, "R4");
        add_evt(4'b1101, 1);
        do_fetch(2, 16'h0000, "R5");
        expect_idle(20, "R5");
        expect_lock(1, 1, "R5");
    endtask

    task automatic t_foreign_unlock;
        add_evt(4'b0100, 1);
        do_fetch(2, 16'h0A00, "R6");
        expect_lock(1, 1, "R6");
        expect_idle(10, "R6");
        add_evt(4'b0010, 1);
        do_fetch(1, 16'h0C00, "R8");
        expect_lock(1, 1, "R8");
    endtask

    task automatic t_release;
        add_evt(4'b0010, 1);
        do_fetch(1, 16'h0A00, "R7");
        expect_lock(0, 0, "R7");
        do_fetch(3, 16'h0000, "R7");
        do_fetch(0, 16'h0000, "R7");
        expect_idle(5, "R7");
    endtask

    task automatic t_both_flags;
        add_evt(4'b0100, 1);
        do_fetch(2, 16'h0E00, "R8");
        expect_lock(0, 0, "R8");
    endtask

    task automatic t_saturate;
        add_evt(4'b1000, 20);
        for (int i = 0; i < 15; i++) do_fetch(3, 16'h0000, "R9");
        expect_idle(10, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_no_cmd();
        t_lock_mask();
        t_foreign_unlock();
        t_release();
        t_both_flags();
        t_saturate();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule